// File: doc/BRIEF.md
# Per-Port Network Exception Flag Controller

This block keeps two sticky error flags for each port of a multi-port network controller: a transmit-retry flag and a receive-discard flag. The transmit-retry flag of a port rises on a late collision, on a missing or lost carrier during transmission, on a transmit FIFO underrun, or when one packet has collided on sixteen attempts in a row. A per-port attempt counter tracks the collisions. The receive-discard flag rises on a discard event from the receive logic. The MAC datapath and the FIFOs are outside the block. They appear only as single-cycle event inputs and as level FIFO-clear outputs.

While a flag is set, the matching FIFO of that port is held cleared, which stops new transmissions or receptions on that port. A flag stays set until a global clear is given. One clear input serves every transmit flag and another serves every receive flag. A per-port receive-abort pulse flushes the receive FIFO for one cycle without touching the flag. The flags are read through two groups of tristate drivers, and each group has its own active-low enable.

Top module: `exc_flag_ctrl`

## Requirements
- R1: After a cycle with `rst` high, all flags are clear, all attempt counters are zero, and `tx_fifo_clr` and `rx_fifo_clr` are all low.
- R2: A one-cycle pulse on `tx_late_col`, `tx_no_carrier` or `tx_underrun` for a port sets that port's transmit-retry flag. The flag is visible from the cycle after the pulse.
- R3: The transmit-retry flag of a port sets on the 16th counted `tx_collision` since the counter was last reset. Fifteen counted collisions leave it clear.
- R4: A `tx_pkt_start` or `tx_done_ok` pulse resets the port's attempt counter to zero. A collision in the same cycle as either of them is not counted.
- R5: A transmit-retry flag stays set until `clr_tx_all` is high. The clear acts on every port's transmit flag in the next cycle.
- R6: If a set cause and the matching global clear arrive in the same cycle, the flag ends up set. This holds for both the transmit and the receive flags.
- R7: `tx_fifo_clr[p]` is high in every cycle that port p's transmit flag is set. While the flag is set, collisions are not counted and the counter stays at zero.
- R8: An `rx_discard` pulse sets the port's receive-discard flag. The flag holds until `clr_rx_all` is high, and `rx_fifo_clr[p]` is high in every cycle that the flag is set.
- R9: An `rx_abort` pulse drives `rx_fifo_clr` high for the following cycle and does not set the receive-discard flag.
- R10: `tx_retry_o` is high-impedance while `tx_oe_n` is high and carries the transmit flags (bit p = port p) while it is low. `rx_discard_o` behaves the same way under `rx_oe_n`. The two enables act independently.
- R11: Events on one port change no flag, counter or clear output of any other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_late_col | input | NPORT | Late collision pulse, one bit per port |
| tx_no_carrier | input | NPORT | Carrier missing or dropped during transmission |
| tx_underrun | input | NPORT | Transmit FIFO underrun during an attempt |
| tx_collision | input | NPORT | Collision on a transmit attempt |
| tx_done_ok | input | NPORT | Packet sent without error |
| tx_pkt_start | input | NPORT | First attempt of a new packet |
| rx_discard | input | NPORT | Receive discard condition |
| rx_abort | input | NPORT | Receive abort request |
| clr_tx_all | input | 1 | Clears every transmit-retry flag |
| clr_rx_all | input | 1 | Clears every receive-discard flag |
| tx_oe_n | input | 1 | Active-low enable of the transmit flag drivers |
| rx_oe_n | input | 1 | Active-low enable of the receive flag drivers |
| tx_retry_o | output | NPORT | Tristate transmit-retry flags |
| rx_discard_o | output | NPORT | Tristate receive-discard flags |
| tx_fifo_clr | output | NPORT | Hold the port's transmit FIFO cleared |
| rx_fifo_clr | output | NPORT | Hold the port's receive FIFO cleared |

## Verification
A wrong attempt counter shows at the ports in one of two ways. The transmit flag either rises one collision early or late, or it rises after a start or a success should have reset the count. The bench therefore counts collisions exactly up to the limit and across resets. A flag that is lost or that rises on its own shows on the enabled tristate bus and on the FIFO-clear output in the next cycle. The bench reads both one cycle after every event and clear. A bad abort register shows as a clear pulse that is missing or lasts too long, and the bench checks the cycle after the abort and the cycle after that.

// File: rtl/exc_pkg.sv
package exc_pkg;

    // Default geometry of the controller.
    localparam int unsigned DEF_NPORT = 4;
    localparam int unsigned DEF_LIMIT = 16;

    // Receive-side state of one port.
    typedef struct packed {
        logic flag;       // sticky discard flag
        logic abort_seen; // abort pulse seen in the previous cycle
    } rx_state_t;

endpackage

// File: rtl/exc_tx_port.sv
module exc_tx_port #(
    parameter int unsigned LIMIT = exc_pkg::DEF_LIMIT
) (
    input  logic clk,
    input  logic rst,
    input  logic late_col,
    input  logic no_carrier,
    input  logic underrun,
    input  logic collision,
    input  logic done_ok,
    input  logic pkt_start,
    input  logic clr_all,
    output logic flag_o,
    output logic fifo_clr_o
);
    localparam int unsigned CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    typedef struct packed {
        logic             flag;
        logic [CNT_W-1:0] cnt;
    } tx_state_t;

    tx_state_t st_q, st_d;
    logic      restart;
    logic      counted;
    logic      limit_hit;
    logic      set_ev;

    always_comb begin
        st_d      = st_q;
        restart   = pkt_start | done_ok;
        counted   = collision & ~restart & ~st_q.flag;
        limit_hit = counted & (st_q.cnt == LAST);
        set_ev    = late_col | no_carrier | underrun | limit_hit;

        if (st_q.flag || restart || limit_hit) begin
            st_d.cnt = '0;
        end else if (counted) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        if (set_ev) begin
            st_d.flag = 1'b1;
        end else if (clr_all) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o     = st_q.flag;
    assign fifo_clr_o = st_q.flag;

    // R1: reset leaves the port idle
    a_r1_tx_reset: assert property (@(posedge clk) rst |=> (!st_q.flag && st_q.cnt == '0));
    // R2: any direct cause raises the flag
    a_r2_direct_cause: assert property (@(posedge clk) disable iff (rst)
        (late_col || no_carrier || underrun) |=> st_q.flag);
    // R4: start or success restarts the count
    a_r4_restart: assert property (@(posedge clk) disable iff (rst)
        (pkt_start || done_ok) |=> st_q.cnt == '0);
    // R5: flag holds without a clear
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_q.flag && !clr_all) |=> st_q.flag);
    // R6: set beats a simultaneous clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        (clr_all && (late_col || no_carrier || underrun)) |=> st_q.flag);
    // R7: counter frozen at zero while flagged
    a_r7_cnt_frozen: assert property (@(posedge clk) disable iff (rst)
        st_q.flag |=> st_q.cnt == '0);
endmodule

// File: rtl/exc_rx_port.sv
module exc_rx_port
    import exc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic discard,
    input  logic abort,
    input  logic clr_all,
    output logic flag_o,
    output logic fifo_clr_o
);
    rx_state_t st_q, st_d;

    always_comb begin
        st_d            = st_q;
        st_d.abort_seen = abort;
        if (discard) begin
            st_d.flag = 1'b1;
        end else if (clr_all) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o     = st_q.flag;
    assign fifo_clr_o = st_q.flag | st_q.abort_seen;

    // R1: reset leaves the receive side idle
    a_r1_rx_reset: assert property (@(posedge clk) rst |=> (!st_q.flag && !fifo_clr_o));
    // R8: discard flag holds without a clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_q.flag && !clr_all) |=> st_q.flag);
    // R6: set beats a simultaneous clear
    a_r6_rx_set_wins: assert property (@(posedge clk) disable iff (rst)
        discard |=> st_q.flag);
    // R9: abort flushes the FIFO next cycle without raising the flag
    a_r9_abort_flush: assert property (@(posedge clk) disable iff (rst)
        (abort && !discard && !st_q.flag) |=> (fifo_clr_o && !st_q.flag));
endmodule

// File: rtl/exc_tri_drv.sv
module exc_tri_drv #(
    parameter int unsigned W = exc_pkg::DEF_NPORT
) (
    input  logic [W-1:0] val,
    input  logic         oe_n,
    output logic [W-1:0] bus_o
);
    assign bus_o = oe_n ? {W{1'bz}} : val;
endmodule

// File: rtl/exc_flag_ctrl.sv
module exc_flag_ctrl #(
    parameter int unsigned NPORT = exc_pkg::DEF_NPORT,
    parameter int unsigned LIMIT = exc_pkg::DEF_LIMIT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] tx_late_col,
    input  logic [NPORT-1:0] tx_no_carrier,
    input  logic [NPORT-1:0] tx_underrun,
    input  logic [NPORT-1:0] tx_collision,
    input  logic [NPORT-1:0] tx_done_ok,
    input  logic [NPORT-1:0] tx_pkt_start,
    input  logic [NPORT-1:0] rx_discard,
    input  logic [NPORT-1:0] rx_abort,
    input  logic             clr_tx_all,
    input  logic             clr_rx_all,
    input  logic             tx_oe_n,
    input  logic             rx_oe_n,
    output logic [NPORT-1:0] tx_retry_o,
    output logic [NPORT-1:0] rx_discard_o,
    output logic [NPORT-1:0] tx_fifo_clr,
    output logic [NPORT-1:0] rx_fifo_clr
);
    logic [NPORT-1:0] tx_flag;
    logic [NPORT-1:0] rx_flag;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        exc_tx_port #(.LIMIT(LIMIT)) u_tx (
            .clk        (clk),
            .rst        (rst),
            .late_col   (tx_late_col[p]),
            .no_carrier (tx_no_carrier[p]),
            .underrun   (tx_underrun[p]),
            .collision  (tx_collision[p]),
            .done_ok    (tx_done_ok[p]),
            .pkt_start  (tx_pkt_start[p]),
            .clr_all    (clr_tx_all),
            .flag_o     (tx_flag[p]),
            .fifo_clr_o (tx_fifo_clr[p])
        );
        exc_rx_port u_rx (
            .clk        (clk),
            .rst        (rst),
            .discard    (rx_discard[p]),
            .abort      (rx_abort[p]),
            .clr_all    (clr_rx_all),
            .flag_o     (rx_flag[p]),
            .fifo_clr_o (rx_fifo_clr[p])
        );
    end

    exc_tri_drv #(.W(NPORT)) u_tx_drv (.val(tx_flag), .oe_n(tx_oe_n), .bus_o(tx_retry_o));
    exc_tri_drv #(.W(NPORT)) u_rx_drv (.val(rx_flag), .oe_n(rx_oe_n), .bus_o(rx_discard_o));

    // R11: a port's FIFO clear only rises together with its own event
    a_r11_tx_isolated: assert property (@(posedge clk) disable iff (rst)
        ((tx_late_col == '0) && (tx_no_carrier == '0) && (tx_underrun == '0)
         && (tx_collision == '0)) |=> ((tx_fifo_clr & ~$past(tx_fifo_clr)) == '0));
endmodule

// File: tb/sim_exc_flag_ctrl.sv
module sim_exc_flag_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NP-1:0] late = '0, nocar = '0, under = '0, col = '0, ok = '0, start = '0;
    logic [NP-1:0] disc = '0, abrt = '0;
    logic clr_tx = 1'b0, clr_rx = 1'b0, tx_oe_n = 1'b0, rx_oe_n = 1'b0;
    wire  [NP-1:0] tx_bus, rx_bus;
    logic [NP-1:0] tx_fc, rx_fc;
    int checks = 0, errors = 0;

    for (genvar i = 0; i < NP; i++) begin : g_pd
        pulldown pd_t (tx_bus[i]);
        pulldown pd_r (rx_bus[i]);
    end

    exc_flag_ctrl u0 (
        .clk(clk), .rst(rst),
        .tx_late_col(late), .tx_no_carrier(nocar), .tx_underrun(under),
        .tx_collision(col), .tx_done_ok(ok), .tx_pkt_start(start),
        .rx_discard(disc), .rx_abort(abrt),
        .clr_tx_all(clr_tx), .clr_rx_all(clr_rx),
        .tx_oe_n(tx_oe_n), .rx_oe_n(rx_oe_n),
        .tx_retry_o(tx_bus), .rx_discard_o(rx_bus),
        .tx_fifo_clr(tx_fc), .rx_fifo_clr(rx_fc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic do_reset();
        rst = 1'b1; tick(); tick(); rst = 1'b0;
    endtask

    task automatic clear_all();
        clr_tx = 1'b1; clr_rx = 1'b1; tick(); clr_tx = 1'b0; clr_rx = 1'b0;
    endtask

    task automatic collide(input int p, input int n);
        for (int k = 0; k < n; k++) begin
            col[p] = 1'b1; tick(); col[p] = 1'b0;
        end
    endtask

    task automatic t_reset();
        late = '1; disc = '1; abrt = '1;
        do_reset();
        late = '0; disc = '0; abrt = '0;
        check("R1 tx flags", tx_bus, 4'b0000);
        check("R1 rx flags", rx_bus, 4'b0000);
        check("R1 tx_fifo_clr", tx_fc, 4'b0000);
        check("R1 rx_fifo_clr", rx_fc, 4'b0000);
    endtask

    task automatic t_causes();
        late[0] = 1'b1; tick(); late[0] = 1'b0;
        check("R2 late collision", tx_bus, 4'b0001);
        nocar[1] = 1'b1; tick(); nocar[1] = 1'b0;
        check("R2 no carrier", tx_bus, 4'b0011);
        under[3] = 1'b1; tick(); under[3] = 1'b0;
        check("R2 underrun", tx_bus, 4'b1011);
        check("R11 port 2 untouched", tx_fc, 4'b1011);
        check("R7 fifo clear follows flags", tx_fc, tx_bus);
        tick(); tick();
        check("R5 flags stay set", tx_bus, 4'b1011);
        clr_tx = 1'b1; tick(); clr_tx = 1'b0;
        check("R5 global clear", tx_bus, 4'b0000);
        check("R5 fifo clear released", tx_fc, 4'b0000);
    endtask

    task automatic t_limit();
        start[2] = 1'b1; tick(); start[2] = 1'b0;
        collide(2, 15);
        check("R3 fifteen collisions", tx_bus, 4'b0000);
        collide(2, 1);
        check("R3 sixteenth collision", tx_bus, 4'b0100);
        check("R11 limit on port 2 only", tx_fc, 4'b0100);
        collide(2, 20);
        clear_all();
        collide(2, 15);
        check("R7 collisions ignored while flagged", tx_bus, 4'b0000);
        start[2] = 1'b1; tick(); start[2] = 1'b0;
    endtask

    task automatic t_restart();
        collide(1, 10);
        ok[1] = 1'b1; tick(); ok[1] = 1'b0;
        collide(1, 15);
        check("R4 success resets count", tx_bus, 4'b0000);
        start[1] = 1'b1; col[1] = 1'b1; tick(); start[1] = 1'b0; col[1] = 1'b0;
        collide(1, 15);
        check("R4 collision with start not counted", tx_bus, 4'b0000);
        collide(1, 1);
        check("R4 count reaches limit after restart", tx_bus, 4'b0010);
        clear_all();
    endtask

    task automatic t_set_wins();
        late[3] = 1'b1; clr_tx = 1'b1; tick(); late[3] = 1'b0; clr_tx = 1'b0;
        check("R6 tx set beats clear", tx_bus, 4'b1000);
        disc[0] = 1'b1; clr_rx = 1'b1; tick(); disc[0] = 1'b0; clr_rx = 1'b0;
        check("R6 rx set beats clear", rx_bus, 4'b0001);
        clear_all();
        check("R6 both cleared afterwards", tx_bus | rx_bus, 4'b0000);
    endtask

    task automatic t_rx();
        disc[2] = 1'b1; tick(); disc[2] = 1'b0;
        check("R8 discard sets flag", rx_bus, 4'b0100);
        tick(); tick();
        check("R8 flag holds", rx_bus, 4'b0100);
        check("R8 rx fifo clear held", rx_fc, 4'b0100);
        clr_rx = 1'b1; tick(); clr_rx = 1'b0;
        check("R8 global clear", rx_bus, 4'b0000);
        check("R8 rx fifo clear released", rx_fc, 4'b0000);
    endtask

    task automatic t_abort();
        abrt[1] = 1'b1; tick(); abrt[1] = 1'b0;
        check("R9 abort flush", rx_fc, 4'b0010);
        check("R9 abort sets no flag", rx_bus, 4'b0000);
        tick();
        check("R9 flush lasts one cycle", rx_fc, 4'b0000);
    endtask

    task automatic t_tristate();
        late[0] = 1'b1; disc[3] = 1'b1; tick(); late[0] = 1'b0; disc[3] = 1'b0;
        tx_oe_n = 1'b1; #1;
        check("R10 tx released (pulled low)", tx_bus, 4'b0000);
        check("R10 rx still driven", rx_bus, 4'b1000);
        rx_oe_n = 1'b1; tx_oe_n = 1'b0; #1;
        check("R10 tx driven", tx_bus, 4'b0001);
        check("R10 rx released (pulled low)", rx_bus, 4'b0000);
        rx_oe_n = 1'b0; #1;
        check("R10 rx driven again", rx_bus, 4'b1000);
        clear_all();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick();
        t_reset();
        t_causes();
        t_limit();
        t_restart();
        t_set_wins();
        t_rx();
        t_abort();
        t_tristate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule